// File: doc/BRIEF.md
# Light-Gun Raster Position Latch

This block records where the video raster is when a light-gun hit is expected. A host presents a screen coordinate (x, y) together with an arm strobe. From that coordinate, the sync timing settings and the field in progress, the block works out a raster target: a frame line and a dot within that line. It then watches the raster line and dot counts coming from an external timing generator.

When the raster reaches the target, the block loads a read-only gun-position word with the current line and dot. In the same cycle it raises a one-cycle notification that starts the peripheral transfer on the controller port. One arm gives at most one capture. After that the block is idle until it is armed again.

A target line that falls outside the frame cancels the request. A target dot past the end of the line is pulled back to the last dot. The bus can write to the gun-position word, but those writes have no effect.

Top module: `lightgun_pos_latch`

## Requirements
- R1: After reset, gunPos is 0 and gunIrq is 0.
- R2: The target frame line is 2*((armY >> 1) + vsyncLines) + oddField. Here oddField is the value sampled in the arm cycle: 1 means odd field, 0 means even field.
- R3: The target dot is armX + hsyncDots. All inputs are sampled in the arm cycle.
- R4: If armX + hsyncDots is greater than lineLen - 1, the target dot becomes lineLen - 1.
- R5: Take the cycle in which the block is waiting and rasterLine and rasterDot equal the target. At the next clock edge, gunPos becomes (rasterLine << 16) | (rasterDot & 0x3FF). All other bits of gunPos are 0.
- R6: gunIrq is high for exactly one cycle. That cycle is the first cycle in which the new gunPos value is visible.
- R7: An arm whose target frame line is greater than or equal to totalLines produces no capture. It also cancels any target that was pending.
- R8: Arming while a target is pending replaces that target. An arm in the same cycle as a raster match wins, and that match is not captured.
- R9: After one capture the block returns to idle. No further capture occurs until the next arm.
- R10: A write (busWrEn = 1) to gunPos, with any busWrData, leaves gunPos unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| armValid | input | 1 | Arm strobe; the coordinate is sampled in this cycle |
| armX | input | COORD_W | Horizontal screen coordinate |
| armY | input | COORD_W | Vertical screen coordinate |
| vsyncLines | input | LINE_W | Vertical sync length in lines |
| hsyncDots | input | DOT_W | Horizontal sync width in dots |
| totalLines | input | LINE_W | Number of lines in a frame |
| lineLen | input | DOT_W | Number of dots in a line |
| rasterLine | input | LINE_W | Current raster line from the timing generator |
| rasterDot | input | DOT_W | Current dot in the line from the timing generator |
| oddField | input | 1 | Current field, 1 = odd |
| busWrEn | input | 1 | Bus write strobe aimed at the gun-position word |
| busWrData | input | WORD_W | Bus write data (ignored) |
| gunPos | output | WORD_W | Captured gun-position word |
| gunIrq | output | 1 | One-cycle notification that starts the port transfer |

## Verification
An arm presented in one cycle becomes the live target at the next rising edge. The earliest cycle in which a match can be seen is the one after that edge. The captured word and the notification then appear at the rising edge that closes the matching cycle.

The bench drives the raster counters itself, with nonblocking updates on the rising edge. It runs a requirement-level model on the same edge and compares gunPos and gunIrq with that model at every falling edge, so every result is checked in the cycle it is due.

Directed cases add exact expected words for the field, clamp, drop, replacement and write cases. In those cases the expected word is computed from the arm-time inputs.

// File: rtl/lgl_pkg.sv
package lgl_pkg;
  localparam int POS_SHIFT   = 16;
  localparam int DOT_FIELD_W = 10;

  typedef enum logic {ST_IDLE, ST_WAIT} lgl_state_e;

  typedef struct packed {
    logic loadTarget;
    logic capture;
  } lgl_strobe_t;
endpackage

// File: rtl/lgl_ctrl.sv
module lgl_ctrl
  import lgl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        armValid,
  input  logic        armOk,
  input  logic        hit,
  output lgl_strobe_t strb,
  output logic        gunIrq
);
  lgl_state_e state;

  always_comb begin
    strb.loadTarget = armValid && armOk;
    // a fresh arm takes priority over a match in the same cycle
    strb.capture    = (state == ST_WAIT) && hit && !armValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      gunIrq <= 1'b0;
    end else begin
      gunIrq <= strb.capture;
      if (armValid)
        state <= armOk ? ST_WAIT : ST_IDLE;
      else if (strb.capture)
        state <= ST_IDLE;
    end
  end
endmodule

// File: rtl/lgl_dpath.sv
module lgl_dpath
  import lgl_pkg::*;
#(
  parameter int LINE_W  = 10,
  parameter int DOT_W   = 10,
  parameter int COORD_W = 10,
  parameter int WORD_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [COORD_W-1:0] armX,
  input  logic [COORD_W-1:0] armY,
  input  logic [LINE_W-1:0] vsyncLines,
  input  logic [DOT_W-1:0]  hsyncDots,
  input  logic [LINE_W-1:0] totalLines,
  input  logic [DOT_W-1:0]  lineLen,
  input  logic              oddField,
  input  logic [LINE_W-1:0] rasterLine,
  input  logic [DOT_W-1:0]  rasterDot,
  input  logic              busWrEn,
  input  logic [WORD_W-1:0] busWrData,
  input  lgl_strobe_t       strb,
  output logic              armOk,
  output logic              hit,
  output logic [WORD_W-1:0] gunPos
);
  localparam int LSUM_W = ((COORD_W > LINE_W) ? COORD_W : LINE_W) + 2;
  localparam int DSUM_W = ((COORD_W > DOT_W) ? COORD_W : DOT_W) + 1;
  // no bit of the gun-position word is writable from the bus
  localparam logic [WORD_W-1:0] WR_MASK = '0;

  logic [LSUM_W-1:0] fieldLine, frameLine;
  logic [DSUM_W-1:0] dotSum, lastDot, dotNext;
  logic [LINE_W-1:0] tLine;
  logic [DOT_W-1:0]  tDot;
  logic [DOT_FIELD_W-1:0] dotField;
  logic [WORD_W-1:0] capWord, gunPosNext;

  always_comb begin
    fieldLine = LSUM_W'(armY >> 1) + LSUM_W'(vsyncLines);
    frameLine = (fieldLine << 1) | LSUM_W'(oddField);
    armOk     = frameLine < LSUM_W'(totalLines);
    dotSum    = DSUM_W'(armX) + DSUM_W'(hsyncDots);
    lastDot   = DSUM_W'(lineLen) - DSUM_W'(1);
    dotNext   = (dotSum > lastDot) ? lastDot : dotSum;
    hit       = (rasterLine == tLine) && (rasterDot == tDot);
    dotField  = DOT_FIELD_W'(rasterDot);
    capWord   = (WORD_W'(rasterLine) << POS_SHIFT) | WORD_W'(dotField);
    if (strb.capture)
      gunPosNext = capWord;
    else if (busWrEn)
      gunPosNext = (gunPos & ~WR_MASK) | (busWrData & WR_MASK);
    else
      gunPosNext = gunPos;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tLine  <= '0;
      tDot   <= '0;
      gunPos <= '0;
    end else begin
      if (strb.loadTarget) begin
        tLine <= LINE_W'(frameLine);
        tDot  <= DOT_W'(dotNext);
      end
      gunPos <= gunPosNext;
    end
  end
endmodule

// File: rtl/lightgun_pos_latch.sv
module lightgun_pos_latch
  import lgl_pkg::*;
#(
  parameter int LINE_W  = 10,
  parameter int DOT_W   = 10,
  parameter int COORD_W = 10,
  parameter int WORD_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               armValid,
  input  logic [COORD_W-1:0] armX,
  input  logic [COORD_W-1:0] armY,
  input  logic [LINE_W-1:0]  vsyncLines,
  input  logic [DOT_W-1:0]   hsyncDots,
  input  logic [LINE_W-1:0]  totalLines,
  input  logic [DOT_W-1:0]   lineLen,
  input  logic [LINE_W-1:0]  rasterLine,
  input  logic [DOT_W-1:0]   rasterDot,
  input  logic               oddField,
  input  logic               busWrEn,
  input  logic [WORD_W-1:0]  busWrData,
  output logic [WORD_W-1:0]  gunPos,
  output logic               gunIrq
);
  lgl_strobe_t strb;
  logic armOk, hit;

  lgl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .armValid(armValid), .armOk(armOk),
    .hit(hit), .strb(strb), .gunIrq(gunIrq)
  );

  lgl_dpath #(.LINE_W(LINE_W), .DOT_W(DOT_W), .COORD_W(COORD_W), .WORD_W(WORD_W)) u_dpath (
    .clk(clk), .rstN(rstN), .armX(armX), .armY(armY),
    .vsyncLines(vsyncLines), .hsyncDots(hsyncDots), .totalLines(totalLines),
    .lineLen(lineLen), .oddField(oddField), .rasterLine(rasterLine),
    .rasterDot(rasterDot), .busWrEn(busWrEn), .busWrData(busWrData),
    .strb(strb), .armOk(armOk), .hit(hit), .gunPos(gunPos)
  );
endmodule

// File: rtl/lgl_checker.sv
module lgl_checker
  import lgl_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int DOT_W  = 10,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              armValid,
  input logic [LINE_W-1:0] totalLines,
  input logic [DOT_W-1:0]  lineLen,
  input logic [LINE_W-1:0] rasterLine,
  input logic [DOT_W-1:0]  rasterDot,
  input logic [WORD_W-1:0] gunPos,
  input logic              gunIrq
);
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    gunIrq |=> !gunIrq); // R6

  AST_POS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !gunIrq |-> $stable(gunPos)); // R10

  AST_POS_IS_RASTER: assert property (@(posedge clk) disable iff (!rstN)
    gunIrq |-> (gunPos[POS_SHIFT +: LINE_W] == $past(rasterLine)) &&
               (gunPos[DOT_FIELD_W-1:0] == DOT_FIELD_W'($past(rasterDot)))); // R5

  AST_ARM_BLOCKS_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    armValid |=> !gunIrq); // R8

  AST_DOT_IN_LINE: assert property (@(posedge clk) disable iff (!rstN)
    gunIrq |-> (gunPos[DOT_FIELD_W-1:0] < DOT_FIELD_W'(lineLen))); // R4

  AST_LINE_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    gunIrq |-> (gunPos[POS_SHIFT +: LINE_W] < totalLines)); // R7
endmodule

bind lightgun_pos_latch lgl_checker #(.LINE_W(LINE_W), .DOT_W(DOT_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .armValid(armValid), .totalLines(totalLines),
  .lineLen(lineLen), .rasterLine(rasterLine), .rasterDot(rasterDot),
  .gunPos(gunPos), .gunIrq(gunIrq)
);

// File: tb/sim_lightgun_pos_latch.sv
`timescale 1ns/1ps
module sim_lightgun_pos_latch;
  logic clk = 0, rstN = 0;
  logic armValid = 0, busWrEn = 0, oddField;
  logic [9:0] armX = 0, armY = 0, vsyncLines = 0, hsyncDots = 0;
  logic [9:0] totalLines = 10'd64, lineLen = 10'd24;
  logic [9:0] rLine, rDot;
  logic [31:0] busWrData = 0, gunPos;
  logic gunIrq;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  lightgun_pos_latch u0 (
    .clk(clk), .rstN(rstN), .armValid(armValid), .armX(armX), .armY(armY),
    .vsyncLines(vsyncLines), .hsyncDots(hsyncDots), .totalLines(totalLines),
    .lineLen(lineLen), .rasterLine(rLine), .rasterDot(rDot), .oddField(oddField),
    .busWrEn(busWrEn), .busWrData(busWrData), .gunPos(gunPos), .gunIrq(gunIrq)
  );

  // timing generator stand-in
  always @(posedge clk) begin
    if (!rstN) begin rLine <= 0; rDot <= 0; oddField <= 0; end
    else if (rDot == lineLen - 1) begin
      rDot <= 0;
      if (rLine == totalLines - 1) begin rLine <= 0; oddField <= ~oddField; end
      else rLine <= rLine + 1;
    end else rDot <= rDot + 1;
  end

  function automatic int tgtLine(int y, int vs, int odd);
    return 2 * ((y >> 1) + vs) + odd;
  endfunction
  function automatic int tgtDot(int x, int hs, int len);
    return (x + hs > len - 1) ? len - 1 : x + hs;
  endfunction
  function automatic logic [31:0] word(int ln, int dt);
    return (32'(ln) << 16) | 32'(dt & 10'h3FF);
  endfunction

  // requirement-level model, same edge as the design
  logic mPend, mIrq; int mLine, mDot; logic [31:0] mPos;
  always @(posedge clk) begin
    if (!rstN) begin mPend <= 0; mIrq <= 0; mPos <= 0; mLine <= 0; mDot <= 0; end
    else begin
      mIrq <= 0;
      if (armValid) begin
        if (tgtLine(armY, vsyncLines, oddField) < totalLines) begin
          mPend <= 1;
          mLine <= tgtLine(armY, vsyncLines, oddField);
          mDot  <= tgtDot(armX, hsyncDots, lineLen);
        end else mPend <= 0;
      end else if (mPend && rLine == mLine && rDot == mDot) begin
        mPend <= 0; mIrq <= 1; mPos <= word(rLine, rDot);
      end
    end
  end

  always @(negedge clk) if (rstN) begin
    if (gunIrq !== mIrq || gunPos !== mPos) begin
      errors++; checks++;
      $display("FAIL R5/R6 model: irq=%0b pos=%h expected irq=%0b pos=%h", gunIrq, gunPos, mIrq, mPos);
    end else if (mIrq) checks++;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  int armOdd;
  task automatic arm(int x, int y, int vs, int hs);
    @(negedge clk);
    armX = 10'(x); armY = 10'(y); vsyncLines = 10'(vs); hsyncDots = 10'(hs);
    armOdd = oddField; armValid = 1;
    @(negedge clk);
    armValid = 0;
  endtask

  task automatic waitIrq(int maxCyc, output bit seen, output logic [31:0] pos);
    seen = 0; pos = 0;
    for (int i = 0; i < maxCyc && !seen; i++) begin
      @(negedge clk);
      if (gunIrq) begin seen = 1; pos = gunPos; end
    end
  endtask

  localparam int FRAME = 64 * 24;

  initial begin
    bit seen; logic [31:0] pos, prev;
    void'($urandom(32'h1A2B3C));
    repeat (3) @(negedge clk);
    check("R1 reset gunPos", gunPos, 0);
    check("R1 reset gunIrq", 32'(gunIrq), 0);
    rstN = 1;

    // R2 R3 basic capture
    arm(5, 10, 3, 2);
    waitIrq(2 * FRAME, seen, pos);
    check("R2 capture seen", 32'(seen), 1);
    check("R3 captured word", pos, word(tgtLine(10, 3, armOdd), 7));
    @(negedge clk);
    check("R6 pulse width", 32'(gunIrq), 0);
    waitIrq(2 * FRAME, seen, pos);
    check("R9 no second capture", 32'(seen), 0);

    // R2 odd field mapping
    while (oddField != 1) @(negedge clk);
    arm(0, 7, 1, 0);
    waitIrq(2 * FRAME, seen, pos);
    check("R2 odd field line", pos, word(tgtLine(7, 1, armOdd), 0));
    check("R2 odd line is odd", 32'(pos[16]), 32'(armOdd));

    // R4 clamp
    arm(30, 4, 2, 5);
    waitIrq(2 * FRAME, seen, pos);
    check("R4 clamped dot", pos, word(tgtLine(4, 2, armOdd), 23));

    // R7 drop, also cancels a pending target
    arm(3, 8, 0, 0);
    arm(3, 63, 7, 0);
    waitIrq(2 * FRAME, seen, pos);
    check("R7 dropped arm", 32'(seen), 0);

    // R8 replace
    arm(1, 50, 4, 1);
    arm(9, 2, 2, 3);
    waitIrq(2 * FRAME, seen, pos);
    check("R8 replaced target", pos, word(tgtLine(2, 2, armOdd), 12));
    waitIrq(2 * FRAME, seen, pos);
    check("R8 old target gone", 32'(seen), 0);

    // R10 bus write ignored
    prev = gunPos;
    @(negedge clk); busWrEn = 1; busWrData = 32'hFFFF_FFFF;
    @(negedge clk); busWrEn = 0; busWrData = 0;
    @(negedge clk);
    check("R10 write ignored", gunPos, prev);

    // constrained random, checked by the model
    for (int n = 0; n < 110; n++) begin
      int w = $urandom_range(0, 1700);
      for (int c = 0; c < w; c++) begin
        @(negedge clk);
        busWrEn = ($urandom_range(0, 15) == 0);
        busWrData = $urandom;
      end
      busWrEn = 0;
      arm($urandom_range(0, 31), $urandom_range(0, 63), $urandom_range(0, 7), $urandom_range(0, 7));
    end
    repeat (2 * FRAME) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule